// File: doc/BRIEF.md
# Audio Frame Sequencer with Interrupt Flag

This block paces the low-rate housekeeping of a sound unit. It advances once per enabled CPU-rate cycle. It keeps an odd/even phase bit that toggles on every enabled cycle. A down-counter walks a six-step sequence. From that sequence the block emits single-cycle quarter-frame and half-frame clock pulses for the channel logic. It also drives a level interrupt flag.

A byte written to the control input selects one of two modes: four-step or five-step. The same byte sets an interrupt-inhibit bit. The write does not restart the sequence at once. It enters a two-stage delay pipe that only advances on even-phase cycles, so the restart lands on a phase-aligned cycle.

A read-clear strobe arms a delayed clear of the interrupt flag. That clear is also serviced only on even-phase cycles. A cold power-up forces four-step mode. A warm reset keeps the mode that was last written.

The per-step reload values for each mode are parameters. An "even cycle" is an enabled cycle whose phase bit is odd before the edge. Both resets leave the phase bit odd, so the first enabled cycle after a reset is even.

Top module: `frame_seq_top`

## Requirements
- R1: While `por` is high, the block clears the inhibit bit, the interrupt flag, the step index, the delay pipe and the delayed-clear flag. It sets the phase to odd, forces four-step mode, loads the counter with the four-step step-0 period, and holds both pulse outputs low.
- R2: While `rst` is high, the block does everything R1 lists except the mode, which keeps its value. The counter loads with the step-0 period of the kept mode.
- R3: On each cycle with `ce` high, the counter decrements. A step fires on the cycle where the count reaches zero. Firing advances the step index (step 5 wraps to 0) and reloads the counter with the period of the new step for the current mode. With `ce` low the counter does not move.
- R4: A firing step 0, 1 or 2 gives a one-cycle `qtr_clk` pulse. A firing step 1 or step 4 gives a one-cycle `half_clk` pulse.
- R5: In four-step mode, a firing step 3 or step 4 sets `irq` whatever the inhibit bit holds. In five-step mode, steps never set `irq`.
- R6: In four-step mode, a firing step 5 loads `irq` with the inverse of the inhibit bit.
- R7: A write (`wr_en` high) loads the mode from `wr_data[7]` (1 means five-step) and the inhibit bit from `wr_data[6]`. When bit 6 is 1, `irq` is low after that edge, even if a step sets it in the same cycle.
- R8: A write sets the upper stage of a two-stage delay pipe. The pipe shifts only on even cycles. On the second even cycle after the write edge, the lower stage is set and the sequence restarts: the step goes to 0 and the counter reloads with the current mode's step-0 period. In five-step mode the restart also gives a `half_clk` pulse. A restart overrides a step that would fire in the same cycle.
- R9: `irq_clr` arms a delayed clear. At the next even cycle, the clear drops `irq` and disarms. A step that sets `irq` in that same cycle wins.
- R10: A cycle with `ce` low and no write leaves `irq` unchanged and gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm reset, synchronous, active high; keeps the mode |
| por | input | 1 | Cold power-up reset, synchronous, active high |
| ce | input | 1 | CPU-rate cycle enable |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data: bit 7 selects the mode, bit 6 sets inhibit |
| irq_clr | input | 1 | Read-clear strobe that arms the delayed clear |
| qtr_clk | output | 1 | Quarter-frame clock pulse |
| half_clk | output | 1 | Half-frame clock pulse |
| irq | output | 1 | Level interrupt flag |

## Verification
The interrupt flag has several writers that can act on the same edge. A step 3 or step 4 firing in four-step mode can coincide with an inhibiting write. A step can also coincide with a pending delayed clear, and a restart can coincide with a step that is due to fire. The bench provokes these collisions by watching its own model of the counter. It drives the write or the clear strobe exactly in the cycle where the count is due to reach zero. The outputs are then judged against the fixed priorities: the write clear beats a step set, a step set beats the delayed clear, and a restart beats a step.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

    typedef enum logic {
        MODE_FOUR = 1'b0,
        MODE_FIVE = 1'b1
    } seq_mode_e;

    localparam int NUM_STEPS = 6;
    localparam int STEP_W    = 3;

    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        logic fire;
        logic irq_set;
        logic irq_val;
    } step_evt_t;

    function automatic step_t step_after(step_t s);
        return (s == step_t'(NUM_STEPS - 1)) ? step_t'(0) : step_t'(s + step_t'(1));
    endfunction

    function automatic logic step_is_quarter(step_t s);
        return (s <= step_t'(2));
    endfunction

    function automatic logic step_is_half(step_t s);
        return (s == step_t'(1)) || (s == step_t'(4));
    endfunction

endpackage

// File: rtl/frame_seq_phase.sv
module frame_seq_phase (
    input  logic clk,
    input  logic rst_any,
    input  logic ce,
    input  logic wr_en,
    input  logic irq_clr,
    output logic restart,
    output logic clr_service
);
    logic odd_q;
    logic pipe_hi_q;
    logic pipe_lo_q;
    logic clr_armed_q;
    logic even_cyc;

    assign even_cyc    = ce && odd_q;
    assign restart     = even_cyc && pipe_lo_q;
    assign clr_service = even_cyc && clr_armed_q;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            odd_q       <= 1'b1;
            pipe_hi_q   <= 1'b0;
            pipe_lo_q   <= 1'b0;
            clr_armed_q <= 1'b0;
        end else begin
            if (ce) begin
                odd_q <= ~odd_q;
                if (odd_q) begin
                    pipe_lo_q <= pipe_hi_q;
                    pipe_hi_q <= 1'b0;
                end
            end
            if (wr_en) begin
                pipe_hi_q <= 1'b1;
            end
            if (irq_clr) begin
                clr_armed_q <= 1'b1;
            end else if (clr_service) begin
                clr_armed_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/frame_seq_steps.sv
module frame_seq_steps
    import frame_seq_pkg::*;
#(
    parameter int                               CW   = 15,
    parameter logic [CW*NUM_STEPS-1:0]          PER4 = {15'd1, 15'd1, 15'd7457, 15'd7458, 15'd7456, 15'd7459},
    parameter logic [CW*NUM_STEPS-1:0]          PER5 = {15'd1, 15'd7452, 15'd7458, 15'd7458, 15'd7456, 15'd7459}
) (
    input  logic      clk,
    input  logic      por,
    input  logic      rst,
    input  logic      ce,
    input  logic      restart,
    input  seq_mode_e mode,
    input  logic      inhibit,
    output step_evt_t evt,
    output logic      qtr_pulse,
    output logic      half_pulse
);
    localparam logic [CW-1:0] ONE = CW'(1);

    step_t         step_q;
    logic [CW-1:0] cnt_q;
    step_t         step_nx;

    function automatic logic [CW-1:0] period_of(seq_mode_e m, step_t s);
        if (m == MODE_FIVE) begin
            return PER5[int'(s)*CW +: CW];
        end
        return PER4[int'(s)*CW +: CW];
    endfunction

    assign step_nx = step_after(step_q);

    always_comb begin
        evt.fire    = ce && !restart && (cnt_q == ONE);
        evt.irq_set = evt.fire && (mode == MODE_FOUR) && (step_q >= step_t'(3));
        evt.irq_val = (step_q == step_t'(NUM_STEPS - 1)) ? ~inhibit : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (por) begin
            step_q     <= '0;
            cnt_q      <= period_of(MODE_FOUR, '0);
            qtr_pulse  <= 1'b0;
            half_pulse <= 1'b0;
        end else if (rst) begin
            step_q     <= '0;
            cnt_q      <= period_of(mode, '0);
            qtr_pulse  <= 1'b0;
            half_pulse <= 1'b0;
        end else begin
            qtr_pulse  <= 1'b0;
            half_pulse <= 1'b0;
            if (ce) begin
                if (restart) begin
                    step_q     <= '0;
                    cnt_q      <= period_of(mode, '0);
                    half_pulse <= (mode == MODE_FIVE);
                end else if (evt.fire) begin
                    step_q     <= step_nx;
                    cnt_q      <= period_of(mode, step_nx);
                    qtr_pulse  <= step_is_quarter(step_q);
                    half_pulse <= step_is_half(step_q);
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/frame_seq_irq.sv
module frame_seq_irq
    import frame_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_any,
    input  logic      wr_clear,
    input  logic      clr_service,
    input  step_evt_t evt,
    output logic      irq
);
    always_ff @(posedge clk) begin
        if (rst_any) begin
            irq <= 1'b0;
        end else if (wr_clear) begin
            irq <= 1'b0;
        end else if (evt.irq_set) begin
            irq <= evt.irq_val;
        end else if (clr_service) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/frame_seq_top.sv
module frame_seq_top
    import frame_seq_pkg::*;
#(
    parameter int                      CW   = 15,
    parameter logic [CW*NUM_STEPS-1:0] PER4 = {15'd1, 15'd1, 15'd7457, 15'd7458, 15'd7456, 15'd7459},
    parameter logic [CW*NUM_STEPS-1:0] PER5 = {15'd1, 15'd7452, 15'd7458, 15'd7458, 15'd7456, 15'd7459}
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic       ce,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       irq_clr,
    output logic       qtr_clk,
    output logic       half_clk,
    output logic       irq
);
    localparam int MODE_BIT = 7;
    localparam int INH_BIT  = 6;

    seq_mode_e mode_q;
    logic      inhibit_q;
    logic      rst_any;
    logic      restart;
    logic      clr_service;
    step_evt_t evt;
    logic      unused_bits;

    assign rst_any     = rst || por;
    assign unused_bits = ^wr_data[5:0];

    always_ff @(posedge clk) begin
        if (por) begin
            mode_q    <= MODE_FOUR;
            inhibit_q <= 1'b0;
        end else if (rst) begin
            inhibit_q <= 1'b0;
        end else if (wr_en) begin
            mode_q    <= seq_mode_e'(wr_data[MODE_BIT]);
            inhibit_q <= wr_data[INH_BIT];
        end
    end

    frame_seq_phase u_phase (
        .clk         (clk),
        .rst_any     (rst_any),
        .ce          (ce),
        .wr_en       (wr_en),
        .irq_clr     (irq_clr),
        .restart     (restart),
        .clr_service (clr_service)
    );

    frame_seq_steps #(
        .CW   (CW),
        .PER4 (PER4),
        .PER5 (PER5)
    ) u_steps (
        .clk        (clk),
        .por        (por),
        .rst        (rst),
        .ce         (ce),
        .restart    (restart),
        .mode       (mode_q),
        .inhibit    (inhibit_q),
        .evt        (evt),
        .qtr_pulse  (qtr_clk),
        .half_pulse (half_clk)
    );

    frame_seq_irq u_irq (
        .clk         (clk),
        .rst_any     (rst_any),
        .wr_clear    (wr_en && wr_data[INH_BIT]),
        .clr_service (clr_service),
        .evt         (evt),
        .irq         (irq)
    );
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk (
    input logic clk,
    input logic rst,
    input logic por,
    input logic ce,
    input logic wr_en,
    input logic wr_inh,
    input logic qtr_clk,
    input logic half_clk,
    input logic irq
);
    a_r1_cold_clear: assert property (@(posedge clk) disable iff (rst)
        por |=> (!irq && !qtr_clk && !half_clk));

    a_r7_inhibit_clears: assert property (@(posedge clk) disable iff (rst || por)
        (wr_en && wr_inh) |=> !irq);

    a_r10_idle_irq_stable: assert property (@(posedge clk) disable iff (rst || por)
        (!ce && !wr_en) |=> $stable(irq));

    a_r10_idle_no_pulse: assert property (@(posedge clk) disable iff (rst || por)
        !ce |=> (!qtr_clk && !half_clk));

    a_r5_irq_rise_needs_ce: assert property (@(posedge clk) disable iff (rst || por)
        $rose(irq) |-> $past(ce));

    a_r4_pulse_needs_ce: assert property (@(posedge clk) disable iff (rst || por)
        (qtr_clk || half_clk) |-> $past(ce));
endmodule

bind frame_seq_top frame_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .por      (por),
    .ce       (ce),
    .wr_en    (wr_en),
    .wr_inh   (wr_data[6]),
    .qtr_clk  (qtr_clk),
    .half_clk (half_clk),
    .irq      (irq)
);

// File: tb/frame_seq_top_tb.sv
module frame_seq_top_tb;
    localparam int CW = 8;
    localparam logic [CW*6-1:0] P4 = {8'd1, 8'd1, 8'd3, 8'd3, 8'd4, 8'd5};
    localparam logic [CW*6-1:0] P5 = {8'd2, 8'd2, 8'd2, 8'd3, 8'd3, 8'd4};

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       por = 1'b0;
    logic       ce = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_clr = 1'b0;
    logic       qtr_clk;
    logic       half_clk;
    logic       irq;

    always #4 clk = ~clk;

    frame_seq_top #(.CW(CW), .PER4(P4), .PER5(P5)) u_dut (
        .clk(clk), .rst(rst), .por(por), .ce(ce), .wr_en(wr_en),
        .wr_data(wr_data), .irq_clr(irq_clr),
        .qtr_clk(qtr_clk), .half_clk(half_clk), .irq(irq)
    );

    typedef struct {
        logic  q;
        logic  h;
        logic  i;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference state, built from the requirements
    bit m_mode, m_inh, m_irq, m_odd, m_hi, m_lo, m_arm;
    int m_step, m_cnt;

    function automatic int per(bit m, int s);
        return m ? int'(P5[s*CW +: CW]) : int'(P4[s*CW +: CW]);
    endfunction

    task automatic drive(input bit c, input bit w, input logic [7:0] d,
                         input bit clr, input bit r, input bit p, input string tag);
        exp_t e;
        bit rs, ds, fire;
        @(negedge clk);
        ce = c; wr_en = w; wr_data = d; irq_clr = clr; rst = r; por = p;
        e.q = 0; e.h = 0; e.tag = tag;
        if (p || r) begin
            if (p) m_mode = 0;
            m_inh = 0; m_irq = 0; m_step = 0; m_cnt = per(m_mode, 0);
            m_odd = 1; m_hi = 0; m_lo = 0; m_arm = 0;
        end else begin
            rs = c && m_odd && m_lo;
            ds = c && m_odd && m_arm;
            fire = c && !rs && (m_cnt == 1);
            if (ds) m_irq = 0;
            if (fire && !m_mode && m_step >= 3) m_irq = (m_step == 5) ? !m_inh : 1'b1;
            if (rs) begin
                m_step = 0; m_cnt = per(m_mode, 0); e.h = m_mode;
            end else if (fire) begin
                e.q = (m_step <= 2);
                e.h = (m_step == 1) || (m_step == 4);
                m_step = (m_step == 5) ? 0 : m_step + 1;
                m_cnt = per(m_mode, m_step);
            end else if (c) begin
                m_cnt = m_cnt - 1;
            end
            if (c) begin
                if (m_odd) begin m_lo = m_hi; m_hi = 0; end
                m_odd = !m_odd;
            end
            if (clr) m_arm = 1; else if (ds) m_arm = 0;
            if (w) begin
                m_hi = 1; m_mode = d[7]; m_inh = d[6];
                if (d[6]) m_irq = 0;
            end
        end
        e.i = m_irq;
        exp_q.push_back(e);
    endtask

    // monitor: compares each expectation after the edge that produced it
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (qtr_clk !== e.q || half_clk !== e.h || irq !== e.i) begin
                fails++;
                $display("FAIL %s: got q=%b h=%b irq=%b expected q=%b h=%b irq=%b",
                         e.tag, qtr_clk, half_clk, irq, e.q, e.h, e.i);
            end
        end
    end

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) drive(1, 0, 8'h00, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_mode = 1;
        drive(0, 0, 8'h00, 0, 0, 1, "R1 cold");
        drive(1, 1, 8'hC0, 1, 0, 1, "R1 cold under stimulus");
        run(60, "R3/R4/R5/R6 four-step run");
        for (int k = 0; k < 60; k++)
            drive((k % 3) != 0, 0, 8'h00, 0, 0, 0, "R10/R3 gapped enable");
        drive(1, 1, 8'h40, 0, 0, 0, "R7 inhibit write");
        run(60, "R6/R8 inhibit step5");
        drive(1, 1, 8'h00, 0, 0, 0, "R7 uninhibit write");
        for (int k = 0; k < 80; k++)
            drive(1, 0, 8'h00, (k % 7) == 0, 0, 0, "R9 delayed clear");
        drive(1, 1, 8'h80, 0, 0, 0, "R7 five-step write");
        run(60, "R8/R5 five-step run");
        drive(1, 0, 8'h00, 0, 1, 0, "R2 warm reset");
        run(40, "R2 mode kept");
        drive(1, 0, 8'h00, 0, 0, 1, "R1 cold again");
        for (int k = 0; k < 120; k++) begin
            if (m_cnt == 1 && (m_step == 3 || m_step == 4) && (k % 2) == 0)
                drive(1, 1, 8'h40, 0, 0, 0, "R7 write clear vs step set");
            else if (m_cnt == 1 && m_step >= 3)
                drive(1, 0, 8'h00, 1, 0, 0, "R9 step set vs delayed clear");
            else if ((k % 17) == 5)
                drive(1, 1, 8'h00, 0, 0, 0, "R8 restart collision");
            else
                drive(1, 0, 8'h00, (k % 5) == 0, 0, 0, "R9/R6 mixed");
        end
        run(2, "R3 drain");
        @(posedge clk); #3;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule